// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a physical address through a small set of large, fixed-size windows, each defined by a register pair. There are two independent sets, one for instruction fetches and one for data accesses. Each set holds four windows. An upper word gives the effective prefix, a length mask and two privilege enables. A lower word gives the physical prefix and the access permission. A lookup presents an address, the access kind, the privilege level and the read/write intent. One cycle later the block reports whether a window claimed the address, the translated address, the granted rights, and whether the requested access breaks those rights.

Software or a configuration controller loads the windows through a one-word write port. It selects the set, the entry and which word of the pair to write. A write takes effect for lookups presented in the cycles after its clock edge. The page-table walk that would follow a miss is handled elsewhere. So is the reporting of the fault to the core.

Top module: `bxl_matcher`

## Requirements
- R1: A lookup with `lk_code`=1 searches only the instruction set (`cfg_side`=1 when written). A lookup with `lk_code`=0 searches only the data set (`cfg_side`=0).
- R2: An entry can match only when effective address bits 31..28 equal upper-word bits 31..28.
- R3: Upper-word bits 12..2 form a length mask aligned to address bits 27..17 (bit 2 to bit 17). Address bits 27..17 with the masked positions cleared must equal upper-word bits 27..17.
- R4: Upper-word bit 1 enables the entry for supervisor lookups (`lk_user`=0). Bit 0 enables it for user lookups (`lk_user`=1). An entry that is not enabled for the current level is skipped.
- R5: When several entries of the searched set match, the lowest-numbered one supplies the result.
- R6: On a hit, physical bits 31..28 come from lower-word bits 31..28. Bits 27..17 are lower-word bits 27..17 ORed with the address bits under the length mask. Bits 16..0 equal the effective address.
- R7: Lower-word bit 1 set grants read and write. Bits 1..0 = 01 grant read only. Bits 1..0 = 00 grant nothing.
- R8: `rs_prot_fault` is 1 on a hit whose granted rights do not cover the request: a write without write right, or a read without read right.
- R9: On a miss, `rs_hit`, `rs_pa`, `rs_rd_ok`, `rs_wr_ok` and `rs_prot_fault` are all 0.
- R10: The result of a lookup presented at a rising edge appears after that edge with `rs_valid`=1. `rs_valid` is 0 after an edge with no lookup. A lookup sees register contents from before a write at the same edge.
- R11: After reset every register word is 0, so every lookup misses, and `rs_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_side | input | 1 | 1 = instruction set, 0 = data set |
| cfg_idx | input | 2 | Entry index |
| cfg_upper | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wdata | input | 32 | Write data |
| lk_req | input | 1 | Lookup request |
| lk_code | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_user | input | 1 | 1 = user level, 0 = supervisor |
| lk_write | input | 1 | 1 = write intent, 0 = read |
| lk_ea | input | 32 | Effective address |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A window claimed the address |
| rs_pa | output | 32 | Physical address |
| rs_rd_ok | output | 1 | Read granted |
| rs_wr_ok | output | 1 | Write granted |
| rs_prot_fault | output | 1 | Hit, but requested access not granted |

## Verification
The hardest situation to reach is two entries of the same set matching one address. They must differ in length mask and privilege enables, so that the priority order and the privilege skip decide the winner together. Random addresses almost never do this. The stimulus therefore programs overlapping windows on purpose: a short supervisor-only window inside a longer window open to both levels. It then aims lookups inside the short window at both privilege levels. The random phase keeps writing new windows with only two prefix values. It draws most addresses from inside programmed windows, so overlaps and writes that coincide with lookups keep occurring.

// File: rtl/bxl_pkg.sv
package bxl_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 11;
  localparam int unsigned OFF_W  = 17;

  typedef enum logic { SIDE_DATA = 1'b0, SIDE_INSN = 1'b1 } side_e;

  typedef struct packed {
    logic              hit;
    logic [WORD_W-1:0] pa;
    logic              rd_ok;
    logic              wr_ok;
  } xl_res_t;

  // Length mask taken from upper word, aligned to address bits 27..17.
  function automatic logic [LEN_W-1:0] len_mask(input logic [WORD_W-1:0] up);
    return up[12:2];
  endfunction

  function automatic logic addr_matches(input logic [WORD_W-1:0] up,
                                        input logic [WORD_W-1:0] ea);
    logic [LEN_W-1:0] keep;
    keep = ~len_mask(up);
    return (ea[31:28] == up[31:28]) &&
           ((ea[27:17] & keep) == up[27:17]);
  endfunction

  function automatic logic level_enabled(input logic [WORD_W-1:0] up,
                                         input logic user);
    return user ? up[0] : up[1];
  endfunction

  function automatic logic [WORD_W-1:0] phys_addr(input logic [WORD_W-1:0] up,
                                                  input logic [WORD_W-1:0] lo,
                                                  input logic [WORD_W-1:0] ea);
    return {lo[31:28], (ea[27:17] & len_mask(up)) | lo[27:17], ea[OFF_W-1:0]};
  endfunction

  function automatic logic grant_rd(input logic [WORD_W-1:0] lo);
    return lo[1] | lo[0];
  endfunction

  function automatic logic grant_wr(input logic [WORD_W-1:0] lo);
    return lo[1];
  endfunction

endpackage

// File: rtl/bxl_regfile.sv
module bxl_regfile
  import bxl_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic                              side,
  input  logic [IDX_W-1:0]                  idx,
  input  logic                              upper,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [ENTRIES-1:0][WORD_W-1:0]    insn_up,
  output logic [ENTRIES-1:0][WORD_W-1:0]    insn_lo,
  output logic [ENTRIES-1:0][WORD_W-1:0]    data_up,
  output logic [ENTRIES-1:0][WORD_W-1:0]    data_lo
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = we && (idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        insn_up[e] <= '0;
        insn_lo[e] <= '0;
        data_up[e] <= '0;
        data_lo[e] <= '0;
      end else if (sel) begin
        unique case ({side, upper})
          {SIDE_INSN, 1'b1}: insn_up[e] <= wdata;
          {SIDE_INSN, 1'b0}: insn_lo[e] <= wdata;
          {SIDE_DATA, 1'b1}: data_up[e] <= wdata;
          default:           data_lo[e] <= wdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/bxl_entry_match.sv
module bxl_entry_match
  import bxl_pkg::*;
(
  input  logic [WORD_W-1:0] up,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  output logic              hit,
  output logic [WORD_W-1:0] pa,
  output logic              rd_ok,
  output logic              wr_ok
);

  assign hit   = addr_matches(up, ea) && level_enabled(up, user);
  assign pa    = phys_addr(up, lo, ea);
  assign rd_ok = grant_rd(lo);
  assign wr_ok = grant_wr(lo);

endmodule

// File: rtl/bxl_pick.sv
module bxl_pick
  import bxl_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]             hit_vec,
  input  logic [ENTRIES-1:0][WORD_W-1:0] pa_vec,
  input  logic [ENTRIES-1:0]             rd_vec,
  input  logic [ENTRIES-1:0]             wr_vec,
  output logic [ENTRIES-1:0]             grant_vec,
  output xl_res_t                        res
);

  // Lowest index wins: an entry is granted when no lower entry hit.
  logic [ENTRIES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_pri
    assign grant_vec[e] = hit_vec[e] && !seen[e];
    assign seen[e+1]    = seen[e] || hit_vec[e];
  end

  always_comb begin
    res = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant_vec[e]) begin
        res.hit   = 1'b1;
        res.pa    = pa_vec[e];
        res.rd_ok = rd_vec[e];
        res.wr_ok = wr_vec[e];
      end
    end
  end

endmodule

// File: rtl/bxl_matcher.sv
module bxl_matcher
  import bxl_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_side,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_upper,
  input  logic [31:0]       cfg_wdata,
  input  logic              lk_req,
  input  logic              lk_code,
  input  logic              lk_user,
  input  logic              lk_write,
  input  logic [31:0]       lk_ea,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [31:0]       rs_pa,
  output logic              rs_rd_ok,
  output logic              rs_wr_ok,
  output logic              rs_prot_fault
);

  logic [ENTRIES-1:0][WORD_W-1:0] insn_up, insn_lo, data_up, data_lo;
  logic [ENTRIES-1:0][WORD_W-1:0] set_up, set_lo, pa_vec;
  logic [ENTRIES-1:0]             hit_vec, rd_vec, wr_vec, grant_vec;
  xl_res_t                        pick_res;
  logic                           fault_now;

  bxl_regfile #(.ENTRIES(ENTRIES)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .side    (cfg_side),
    .idx     (cfg_idx),
    .upper   (cfg_upper),
    .wdata   (cfg_wdata),
    .insn_up (insn_up),
    .insn_lo (insn_lo),
    .data_up (data_up),
    .data_lo (data_lo)
  );

  assign set_up = lk_code ? insn_up : data_up;
  assign set_lo = lk_code ? insn_lo : data_lo;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    bxl_entry_match cmp_i (
      .up    (set_up[e]),
      .lo    (set_lo[e]),
      .ea    (lk_ea),
      .user  (lk_user),
      .hit   (hit_vec[e]),
      .pa    (pa_vec[e]),
      .rd_ok (rd_vec[e]),
      .wr_ok (wr_vec[e])
    );
  end

  bxl_pick #(.ENTRIES(ENTRIES)) pick_i (
    .hit_vec   (hit_vec),
    .pa_vec    (pa_vec),
    .rd_vec    (rd_vec),
    .wr_vec    (wr_vec),
    .grant_vec (grant_vec),
    .res       (pick_res)
  );

  assign fault_now = pick_res.hit &&
                     (lk_write ? !pick_res.wr_ok : !pick_res.rd_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid      <= 1'b0;
      rs_hit        <= 1'b0;
      rs_pa         <= '0;
      rs_rd_ok      <= 1'b0;
      rs_wr_ok      <= 1'b0;
      rs_prot_fault <= 1'b0;
    end else begin
      rs_valid <= lk_req;
      if (lk_req) begin
        rs_hit        <= pick_res.hit;
        rs_pa         <= pick_res.pa;
        rs_rd_ok      <= pick_res.rd_ok;
        rs_wr_ok      <= pick_res.wr_ok;
        rs_prot_fault <= fault_now;
      end
    end
  end

endmodule

// File: rtl/bxl_checker.sv
module bxl_checker #(
  parameter int unsigned ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [31:0]        lk_ea,
  input logic               rs_valid,
  input logic               rs_hit,
  input logic [31:0]        rs_pa,
  input logic               rs_rd_ok,
  input logic               rs_wr_ok,
  input logic               rs_prot_fault,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] grant_vec
);

  assert_valid_tracks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);

  assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rs_valid);

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_grant_from_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~hit_vec) == '0);

  assert_offset_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!rs_hit || rs_pa[16:0] == $past(lk_ea[16:0])));

  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_pa == '0 && !rs_rd_ok && !rs_wr_ok && !rs_prot_fault));

  assert_write_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (!rs_wr_ok || rs_rd_ok));

  assert_fault_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_prot_fault) |-> rs_hit);

endmodule

bind bxl_matcher bxl_checker #(.ENTRIES(ENTRIES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_req        (lk_req),
  .lk_ea         (lk_ea),
  .rs_valid      (rs_valid),
  .rs_hit        (rs_hit),
  .rs_pa         (rs_pa),
  .rs_rd_ok      (rs_rd_ok),
  .rs_wr_ok      (rs_wr_ok),
  .rs_prot_fault (rs_prot_fault),
  .hit_vec       (hit_vec),
  .grant_vec     (grant_vec)
);

// File: tb/bxl_matcher_tb.sv
module bxl_matcher_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_side = 1'b0, cfg_upper = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_req = 1'b0, lk_code = 1'b0, lk_user = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        rs_valid, rs_hit, rs_rd_ok, rs_wr_ok, rs_prot_fault;
  logic [31:0] rs_pa;

  always #2 clk = ~clk;

  bxl_matcher dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx),
    .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .lk_req(lk_req), .lk_code(lk_code), .lk_user(lk_user),
    .lk_write(lk_write), .lk_ea(lk_ea),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_pa(rs_pa),
    .rs_rd_ok(rs_rd_ok), .rs_wr_ok(rs_wr_ok), .rs_prot_fault(rs_prot_fault)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference register model: [0] = data set, [1] = instruction set.
  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  logic        e_valid, e_hit, e_rd, e_wr, e_flt;
  logic [31:0] e_pa;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ref_model(input bit code, input bit user, input bit wr,
                           input logic [31:0] ea);
    int s;
    s = code ? 1 : 0;
    e_hit = 0; e_pa = 0; e_rd = 0; e_wr = 0; e_flt = 0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] u, l, bl, mid_ea, mid_u;
      bit en;
      u = m_up[s][k];
      l = m_lo[s][k];
      bl = (u >> 2) & 32'h7FF;
      mid_ea = (ea >> 17) & 32'h7FF;
      mid_u = (u >> 17) & 32'h7FF;
      en = user ? u[0] : u[1];
      if (!e_hit && en && ((ea ^ u) >> 28) == 0 && (mid_ea & ~bl) == mid_u) begin
        e_hit = 1;
        e_pa = (l & 32'hF000_0000) |
               (((mid_ea & bl) | ((l >> 17) & 32'h7FF)) << 17) |
               (ea & 32'h1FFFF);
        e_rd = (l & 3) != 0;
        e_wr = (l & 2) != 0;
        e_flt = wr ? !e_wr : !e_rd;
      end
    end
  endtask

  // One clock: model the lookup with the old registers, apply the write, compare.
  task automatic cycle();
    e_valid = lk_req;
    if (lk_req) ref_model(lk_code, lk_user, lk_write, lk_ea);
    if (cfg_we) begin
      if (cfg_upper) m_up[cfg_side ? 1 : 0][cfg_idx] = cfg_wdata;
      else           m_lo[cfg_side ? 1 : 0][cfg_idx] = cfg_wdata;
    end
    @(posedge clk);
    #1;
    chk("R10", "valid", 32'(rs_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R3", "hit", 32'(rs_hit), 32'(e_hit));
      chk("R6", "pa", rs_pa, e_pa);
      chk("R7", "rd_ok", 32'(rs_rd_ok), 32'(e_rd));
      chk("R7", "wr_ok", 32'(rs_wr_ok), 32'(e_wr));
      chk("R8", "fault", 32'(rs_prot_fault), 32'(e_flt));
    end
    cfg_we = 0;
    lk_req = 0;
  endtask

  task automatic wr_reg(input bit side, input int idx, input bit up, input logic [31:0] d);
    cfg_we = 1; cfg_side = side; cfg_idx = 2'(idx); cfg_upper = up; cfg_wdata = d;
    cycle();
  endtask

  task automatic look(input bit code, input bit user, input bit wr, input logic [31:0] ea);
    lk_req = 1; lk_code = code; lk_user = user; lk_write = wr; lk_ea = ea;
    cycle();
  endtask

  function automatic logic [31:0] mk_up(input logic [3:0] pfx, input logic [10:0] mid,
                                        input logic [10:0] bl, input bit sv, input bit us);
    return {pfx, mid, 4'b0, bl, sv, us};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [3:0] pfx, input logic [10:0] mid,
                                        input logic [1:0] pp);
    return {pfx, mid, 15'b0, pp};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++) begin m_up[s][k] = 0; m_lo[s][k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "valid in reset", 32'(rs_valid), 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R11", "valid after reset", 32'(rs_valid), 32'h0);

    // R11 / R9: empty registers miss on both sides
    look(0, 0, 0, 32'h8001_2345);
    look(1, 1, 1, 32'h0000_0000);

    // Data entry 0: 128 KB supervisor-only window, read/write
    wr_reg(0, 0, 1, mk_up(4'h8, 11'h000, 11'h000, 1, 0));
    wr_reg(0, 0, 0, mk_lo(4'h1, 11'h005, 2'b10));
    look(0, 0, 0, 32'h8001_2345);   // hit, RW
    look(0, 0, 1, 32'h8001_2345);   // write allowed
    look(0, 1, 0, 32'h8001_2345);   // R4: user not enabled, miss
    look(1, 0, 0, 32'h8001_2345);   // R1: code side empty, miss
    look(0, 0, 0, 32'h9001_2345);   // R2: prefix differs
    look(0, 0, 0, 32'h8002_0000);   // R3: bit 17 not masked

    // Data entry 1: 2 MB window for both levels, read only
    wr_reg(0, 1, 1, mk_up(4'h8, 11'h000, 11'h00F, 1, 1));
    wr_reg(0, 1, 0, mk_lo(4'h2, 11'h010, 2'b01));
    look(0, 0, 0, 32'h8003_0000);   // R3 masked match via entry 1, R6 OR of masked bits
    look(0, 0, 1, 32'h8003_0000);   // R8 write to read-only
    look(0, 0, 0, 32'h8001_0000);   // R5 entry 0 wins
    look(0, 1, 0, 32'h8001_0000);   // R4/R5 user skips entry 0
    look(0, 0, 0, 32'h8020_0000);   // R3 beyond 2 MB: miss

    // Instruction entry 2: no-access window
    wr_reg(1, 2, 1, mk_up(4'hA, 11'h001, 11'h000, 1, 1));
    wr_reg(1, 2, 0, mk_lo(4'h3, 11'h000, 2'b00));
    look(1, 0, 0, 32'hA002_0004);   // R1 code hit, R7 none, R8 read fault
    look(0, 0, 0, 32'hA002_0004);   // R1 data side misses
    look(1, 1, 0, 32'hA002_0004);

    // R10: write and lookup at the same edge; lookup sees old contents
    cfg_we = 1; cfg_side = 0; cfg_idx = 3; cfg_upper = 1;
    cfg_wdata = mk_up(4'hC, 11'h000, 11'h7FF, 1, 1);
    lk_req = 1; lk_code = 0; lk_user = 0; lk_write = 0; lk_ea = 32'hC000_0000;
    cycle();
    look(0, 0, 0, 32'hC123_4567);
    cycle();                        // idle cycle, valid low

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1;
        cfg_side = 1'($urandom);
        cfg_idx = 2'($urandom);
        cfg_upper = 1'($urandom);
        if (cfg_upper)
          cfg_wdata = mk_up($urandom_range(0, 1) ? 4'h8 : 4'h9, 11'($urandom),
                            11'($urandom), 1'($urandom), 1'($urandom));
        else
          cfg_wdata = $urandom;
      end
      if ($urandom_range(0, 5) != 0) begin
        int s, k;
        logic [31:0] u, bl;
        lk_req = 1;
        lk_code = 1'($urandom);
        lk_user = 1'($urandom);
        lk_write = 1'($urandom);
        s = lk_code ? 1 : 0;
        k = $urandom_range(0, 3);
        u = m_up[s][k];
        bl = ((u >> 2) & 32'h7FF) << 17;
        if ($urandom_range(0, 3) == 0) lk_ea = $urandom;
        else lk_ea = (u & 32'hFFFE_0000 & ~bl) | ($urandom & bl) | ($urandom & 32'h1FFFF);
      end
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule